// File: doc/BRIEF.md
# Back-Pressured Priority Cell Queue Scheduler

This block is the input buffering stage of a small cell switch. Two input lines each offer at most one cell per clock. A cell is reduced to a short tag and comes with a destination line, a class bit (guaranteed or best effort), a multicast flag and a low-priority bit. Every cell is written into one of 34 FIFO queues. For each of the 16 destination lines there is one guaranteed queue and one best-effort queue. Each class also has one multicast queue. When both lines deliver in the same cycle, both cells are stored in that cycle, and the line 0 cell goes first.

The input side has no ready signal, so cells are never stalled. A cell that cannot be stored is dropped, and `drop_count` reports in the same cycle how many of the offered cells were refused. The output side is a valid/ready stream:
- `out_valid` means a head cell is being offered.
- A cell leaves on a clock edge where both `out_valid` and `out_ready` are high.
- While `out_ready` is low the same cell stays offered, unless back pressure or a new guaranteed arrival changes the choice.
- `out_valid` may fall without a handshake when the back pressure pattern changes.

Queue selection follows these rules:
- A unicast queue may send only while its destination line is not back-pressured.
- A multicast queue may send only while no line is back-pressured.
- Guaranteed queues always win over best-effort queues.
- Within a class, eligible queues are served round-robin by line index, and the multicast queue of that class takes the slot after line 15.

Top module: `bp_cell_sched`

## Requirements
- R1: A cell is stored in the queue of its class for its destination line, or in its class's multicast queue when `in_mcast` is 1 (in that case `in_dest` is ignored). Cells in one queue leave in arrival order. `in_guar`=1 selects the guaranteed class.
- R2: When both lines offer a cell in the same cycle, both are stored if space allows. If they target the same queue, the line 0 cell is stored ahead of the line 1 cell. The line 1 admission check counts the line 0 cell of that cycle.
- R3: A unicast cell is offered only while `bp[dest]` is 0.
- R4: A multicast cell is offered only while all `bp` bits are 0.
- R5: While any guaranteed queue is eligible, no best-effort cell is offered.
- R6: A cell with `in_lowpri`=1 is dropped when its queue already holds more than 6 cells (7 or 8). At 6 cells or fewer it is stored.
- R7: Each queue holds 8 cells. A cell of either priority arriving at a full queue is dropped. `drop_count` (0 to 2) gives the number of cells refused in the current cycle.
- R8: At most one cell leaves per clock, on `out_valid && out_ready`. It presents the tag, the destination, `out_mcast` and `out_guar`. For a multicast cell `out_dest` is 0. While stalled with unchanged `bp`, `out_valid` stays high.
- R9: Within a class, eligible queues are served round-robin in line order 0 to 15, with the multicast queue after line 15. The pointer moves to the slot after the served one.
- R10: A synchronous active-high `rst` empties all queues and returns both round-robin pointers to line 0. After reset `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 2 | Cell present on line 0 / line 1 |
| in_tag | input | 2xTAG_W | Cell tag per line |
| in_dest | input | 2x4 | Destination line per input |
| in_guar | input | 2 | 1 = guaranteed class, 0 = best effort |
| in_mcast | input | 2 | 1 = multicast cell |
| in_lowpri | input | 2 | 1 = discardable above threshold |
| bp | input | 16 | Back pressure per destination line |
| out_valid | output | 1 | Head cell offered |
| out_ready | input | 1 | Downstream accepts the offered cell |
| out_tag | output | TAG_W | Tag of offered cell |
| out_dest | output | 4 | Destination line (0 for multicast) |
| out_mcast | output | 1 | Offered cell is multicast |
| out_guar | output | 1 | Offered cell is guaranteed class |
| drop_count | output | 2 | Cells refused this cycle |

## Verification
The queues are filled while the output is stalled, then drained, and the exact departure order is compared with the expected order. This order separates several possible faults:
- Queue mapping faults and arrival-order faults, using one cell per cycle and then same-cycle pairs into one queue.
- Class precedence faults, using a best-effort cell loaded before a guaranteed one.
- Round-robin faults, including a wrong position for the multicast slot, using cells spread over several lines plus a multicast cell.

A queue is then filled one cell at a time up to the threshold and up to full, with normal and low-priority cells mixed. This separates the threshold drop from the full drop and checks the same-cycle count that line 1 sees. Back pressure on the destination line, and on an unrelated line, separates unicast blocking from multicast blocking.

// File: rtl/bp_cell_pkg.sv
package bp_cell_pkg;

  typedef enum logic {
    CLS_BEST = 1'b0,
    CLS_GUAR = 1'b1
  } cell_cls_e;

  // wrap-around increment of a slot index in [0, n)
  function automatic int slot_after(input int v, input int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/cq_fifo.sv
module cq_fifo #(
  parameter int DEPTH  = 8,
  parameter int THRESH = 6,
  parameter int W      = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr0_v,
  input  logic         wr0_low,
  input  logic [W-1:0] wr0_data,
  input  logic         wr1_v,
  input  logic         wr1_low,
  input  logic [W-1:0] wr1_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         not_empty,
  output logic         drop0,
  output logic         drop1
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt, cnt_mid;
  logic [AW-1:0] wp, rp, wp1, wp2, rp1;
  logic          ok0, ok1;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // admission: line 0 sees the stored count, line 1 also counts line 0's cell
  always_comb begin
    ok0     = wr0_v && (cnt < CW'(DEPTH)) && !(wr0_low && cnt > CW'(THRESH));
    cnt_mid = cnt + CW'(ok0);
    ok1     = wr1_v && (cnt_mid < CW'(DEPTH)) && !(wr1_low && cnt_mid > CW'(THRESH));
    drop0   = wr0_v && !ok0;
    drop1   = wr1_v && !ok1;
    wp1     = ptr_inc(wp);
    wp2     = ptr_inc(wp1);
    rp1     = ptr_inc(rp);
  end

  always_ff @(posedge clk) begin
    if (ok0 && ok1) begin
      mem[wp]  <= wr0_data;
      mem[wp1] <= wr1_data;
    end else if (ok0) begin
      mem[wp] <= wr0_data;
    end else if (ok1) begin
      mem[wp] <= wr1_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      wp  <= '0;
      rp  <= '0;
    end else begin
      if (ok0 && ok1)     wp <= wp2;
      else if (ok0 || ok1) wp <= wp1;
      if (pop) rp <= rp1;
      cnt <= cnt + CW'(ok0) + CW'(ok1) - CW'(pop);
    end
  end

  assign head      = mem[rp];
  assign not_empty = (cnt != '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH)); // R7
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    pop |-> cnt != '0); // R8
  AST_LOWPRI_DROP: assert property (@(posedge clk) disable iff (rst)
    (wr0_v && wr0_low && cnt > CW'(THRESH) && !wr1_v && !pop) |=> cnt == $past(cnt)); // R6

endmodule

// File: rtl/cq_rr_pick.sv
module cq_rr_pick #(
  parameter int N  = 17,
  parameter int PW = 5
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic          any,
  output logic [PW-1:0] idx
);
  // first requester at or after ptr, wrapping past N-1
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      int j;
      j = int'(ptr) + i;
      if (j >= N) j = j - N;
      if (!any && req[j]) begin
        any = 1'b1;
        idx = PW'(j);
      end
    end
  end
endmodule

// File: rtl/cq_sched.sv
module cq_sched
  import bp_cell_pkg::*;
#(
  parameter int NUM_LINES = 16
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [NUM_LINES:0]                   ne_g,
  input  logic [NUM_LINES:0]                   ne_b,
  input  logic [NUM_LINES-1:0]                 bp,
  input  logic                                 out_ready,
  output logic                                 sel_valid,
  output cell_cls_e                            sel_cls,
  output logic [$clog2(NUM_LINES + 1)-1:0]     sel_slot
);
  localparam int NSLOT = NUM_LINES + 1;
  localparam int PW    = $clog2(NSLOT);

  logic [NSLOT-1:0] elig_g, elig_b;
  logic [PW-1:0]    ptr_g, ptr_b, idx_g, idx_b;
  logic             any_g, any_b, fire;
  logic             no_bp;

  assign no_bp = (bp == '0);

  for (genvar k = 0; k < NSLOT; k++) begin : g_elig
    if (k < NUM_LINES) begin : g_uni
      assign elig_g[k] = ne_g[k] && !bp[k];
      assign elig_b[k] = ne_b[k] && !bp[k];
    end else begin : g_mc
      assign elig_g[k] = ne_g[k] && no_bp;
      assign elig_b[k] = ne_b[k] && no_bp;
    end
  end

  cq_rr_pick #(.N(NSLOT), .PW(PW)) u_pick_g (
    .req(elig_g), .ptr(ptr_g), .any(any_g), .idx(idx_g));
  cq_rr_pick #(.N(NSLOT), .PW(PW)) u_pick_b (
    .req(elig_b), .ptr(ptr_b), .any(any_b), .idx(idx_b));

  assign sel_valid = any_g || any_b;
  assign sel_cls   = any_g ? CLS_GUAR : CLS_BEST;
  assign sel_slot  = any_g ? idx_g : idx_b;
  assign fire      = sel_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_g <= '0;
      ptr_b <= '0;
    end else if (fire) begin
      if (sel_cls == CLS_GUAR) ptr_g <= PW'(slot_after(int'(idx_g), NSLOT));
      else                     ptr_b <= PW'(slot_after(int'(idx_b), NSLOT));
    end
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (ptr_g <= PW'(NUM_LINES)) && (ptr_b <= PW'(NUM_LINES))); // R9
  AST_PTR_STILL: assert property (@(posedge clk) disable iff (rst)
    !out_ready |=> $stable(ptr_g) && $stable(ptr_b)); // R9

endmodule

// File: rtl/bp_cell_sched.sv
module bp_cell_sched
  import bp_cell_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int DEPTH     = 8,
  parameter int THRESH    = 6,
  parameter int TAG_W     = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [1:0]                           in_valid,
  input  logic [1:0][TAG_W-1:0]                in_tag,
  input  logic [1:0][$clog2(NUM_LINES)-1:0]    in_dest,
  input  logic [1:0]                           in_guar,
  input  logic [1:0]                           in_mcast,
  input  logic [1:0]                           in_lowpri,
  input  logic [NUM_LINES-1:0]                 bp,
  output logic                                 out_valid,
  input  logic                                 out_ready,
  output logic [TAG_W-1:0]                     out_tag,
  output logic [$clog2(NUM_LINES)-1:0]         out_dest,
  output logic                                 out_mcast,
  output logic                                 out_guar,
  output logic [1:0]                           drop_count
);
  localparam int LW    = $clog2(NUM_LINES);
  localparam int NSLOT = NUM_LINES + 1;
  localparam int PW    = $clog2(NSLOT);
  localparam int NQ    = 2 * NSLOT;
  localparam int QW    = $clog2(NQ);

  logic [1:0][QW-1:0] qsel;
  logic [TAG_W-1:0]   head [NQ];
  logic [NQ-1:0]      ne, d0, d1, pop;
  logic [NSLOT-1:0]   ne_g, ne_b;
  logic               sel_valid, fire;
  cell_cls_e          sel_cls;
  logic [PW-1:0]      sel_slot;
  logic [QW-1:0]      pop_q;

  // queue index: guaranteed slots 0..NUM_LINES, best-effort slots follow
  for (genvar l = 0; l < 2; l++) begin : g_route
    logic [PW-1:0] slot;
    assign slot    = in_mcast[l] ? PW'(NUM_LINES) : PW'(in_dest[l]);
    assign qsel[l] = in_guar[l] ? QW'(slot) : QW'(slot) + QW'(NSLOT);
  end

  for (genvar q = 0; q < NQ; q++) begin : g_q
    cq_fifo #(.DEPTH(DEPTH), .THRESH(THRESH), .W(TAG_W)) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .wr0_v    (in_valid[0] && qsel[0] == QW'(q)),
      .wr0_low  (in_lowpri[0]),
      .wr0_data (in_tag[0]),
      .wr1_v    (in_valid[1] && qsel[1] == QW'(q)),
      .wr1_low  (in_lowpri[1]),
      .wr1_data (in_tag[1]),
      .pop      (pop[q]),
      .head     (head[q]),
      .not_empty(ne[q]),
      .drop0    (d0[q]),
      .drop1    (d1[q])
    );
    assign pop[q] = fire && (pop_q == QW'(q));
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_split
    assign ne_g[k] = ne[k];
    assign ne_b[k] = ne[NSLOT + k];
  end

  cq_sched #(.NUM_LINES(NUM_LINES)) u_sched (
    .clk      (clk),
    .rst      (rst),
    .ne_g     (ne_g),
    .ne_b     (ne_b),
    .bp       (bp),
    .out_ready(out_ready),
    .sel_valid(sel_valid),
    .sel_cls  (sel_cls),
    .sel_slot (sel_slot)
  );

  assign pop_q = (sel_cls == CLS_GUAR) ? QW'(sel_slot) : QW'(sel_slot) + QW'(NSLOT);
  assign fire  = sel_valid && out_ready;

  always_comb begin
    out_valid = sel_valid;
    out_tag   = '0;
    out_dest  = '0;
    out_mcast = 1'b0;
    out_guar  = 1'b0;
    if (sel_valid) begin
      out_tag   = head[pop_q];
      out_mcast = (sel_slot == PW'(NUM_LINES));
      out_dest  = out_mcast ? '0 : sel_slot[LW-1:0];
      out_guar  = (sel_cls == CLS_GUAR);
    end
    drop_count = {1'b0, |d0} + {1'b0, |d1};
  end

  AST_UNICAST_BP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_mcast) |-> !bp[out_dest]); // R3
  AST_MCAST_BP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_mcast) |-> bp == '0); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid || bp != $past(bp))); // R8
  AST_SINGLE_POP: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pop)); // R8
  AST_RESET_EMPTY: assert property (@(posedge clk)
    $past(rst) |-> !out_valid); // R10

endmodule

// File: tb/bp_cell_sched_test.sv
module bp_cell_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 16;
  localparam int TW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] in_valid = '0, in_guar = '0, in_mcast = '0, in_lowpri = '0;
  logic [1:0][TW-1:0] in_tag = '0;
  logic [1:0][3:0] in_dest = '0;
  logic [NL-1:0] bp = '0;
  logic out_ready = 1'b0;
  logic out_valid, out_mcast, out_guar;
  logic [TW-1:0] out_tag;
  logic [3:0] out_dest;
  logic [1:0] drop_count;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [13:0] sb [$];   // {guar, mcast, dest[3:0], tag[7:0]}

  bp_cell_sched uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag), .in_dest(in_dest),
    .in_guar(in_guar), .in_mcast(in_mcast), .in_lowpri(in_lowpri), .bp(bp),
    .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag), .out_dest(out_dest),
    .out_mcast(out_mcast), .out_guar(out_guar), .drop_count(drop_count));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare each handshake with the scoreboard head
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      logic [13:0] got;
      got = {out_guar, out_mcast, out_dest, out_tag};
      if (sb.size() == 0) check(cur_req, "unexpected cell", int'(got), -1);
      else check(cur_req, "departure", int'(got), int'(sb.pop_front()));
    end
  end

  task automatic expect_cell(input logic [7:0] tag, input logic [3:0] dest,
                             input logic mc, input logic g);
    sb.push_back({g, mc, dest, tag});
  endtask

  task automatic do_reset();
    rst = 1'b1; out_ready = 1'b0; bp = '0; in_valid = '0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic put(input int l, input logic [7:0] tag, input logic [3:0] dest,
                     input logic g, input logic mc, input logic low);
    in_valid[l] = 1'b1; in_tag[l] = tag; in_dest[l] = dest;
    in_guar[l] = g; in_mcast[l] = mc; in_lowpri[l] = low;
  endtask

  task automatic step(input string req, input int exp_drop);
    @(negedge clk);
    check(req, "drop_count", int'(drop_count), exp_drop);
    @(posedge clk); #1;
    in_valid = '0;
  endtask

  task automatic drain(input string req);
    cur_req = req;
    out_ready = 1'b1;
    for (int i = 0; i < 60 && sb.size() != 0; i++) begin
      @(posedge clk); #1;
    end
    out_ready = 1'b0;
    check(req, "scoreboard left", sb.size(), 0);
    sb.delete();
  endtask

  task automatic check_idle(input string req);
    @(negedge clk);
    check(req, "out_valid idle", int'(out_valid), 0);
    @(posedge clk); #1;
  endtask

  initial begin
    do_reset();
    // R10: reset state
    @(negedge clk);
    check("R10", "out_valid after reset", int'(out_valid), 0);
    check("R10", "drop_count after reset", int'(drop_count), 0);
    @(posedge clk); #1;

    // R1 / R2: same-cycle pair into one queue, then a best-effort cell
    put(0, 8'h11, 4'd3, 1, 0, 0); put(1, 8'h12, 4'd3, 1, 0, 0); step("R2", 0);
    put(0, 8'h21, 4'd5, 0, 0, 0); step("R1", 0);
    @(negedge clk);
    check("R8", "stall valid", int'(out_valid), 1);
    check("R8", "stall tag", int'(out_tag), 'h11);
    @(negedge clk);
    check("R8", "stall tag held", int'(out_tag), 'h11);
    @(posedge clk); #1;
    expect_cell(8'h11, 4'd3, 0, 1); expect_cell(8'h12, 4'd3, 0, 1);
    expect_cell(8'h21, 4'd5, 0, 0);
    drain("R2");

    // R9: round robin with multicast after line 15
    do_reset();
    put(0, 8'hA1, 4'd1, 1, 0, 0); put(1, 8'hB1, 4'd4, 1, 0, 0); step("R9", 0);
    put(0, 8'hA2, 4'd1, 1, 0, 0); put(1, 8'hC1, 4'd9, 1, 1, 0); step("R9", 0);
    expect_cell(8'hA1, 4'd1, 0, 1); expect_cell(8'hB1, 4'd4, 0, 1);
    expect_cell(8'hC1, 4'd0, 1, 1); expect_cell(8'hA2, 4'd1, 0, 1);
    drain("R9");

    // R3: back pressure on the guaranteed destination lets best effort through
    do_reset();
    bp[7] = 1'b1;
    put(0, 8'hD1, 4'd7, 1, 0, 0); put(1, 8'hC2, 4'd2, 0, 0, 0); step("R3", 0);
    expect_cell(8'hC2, 4'd2, 0, 0);
    drain("R3");
    check_idle("R3");
    bp[7] = 1'b0;
    expect_cell(8'hD1, 4'd7, 0, 1);
    drain("R3");

    // R4: any back pressure blocks multicast
    do_reset();
    bp[0] = 1'b1;
    put(0, 8'h5A, 4'd6, 1, 1, 0); put(1, 8'hE1, 4'd9, 0, 0, 0); step("R4", 0);
    expect_cell(8'hE1, 4'd9, 0, 0);
    drain("R4");
    check_idle("R4");
    bp[0] = 1'b0;
    expect_cell(8'h5A, 4'd0, 1, 1);
    drain("R4");

    // R5: guaranteed before earlier best effort
    do_reset();
    put(0, 8'hF1, 4'd0, 0, 0, 0); step("R5", 0);
    put(1, 8'h61, 4'd15, 1, 0, 0); step("R5", 0);
    expect_cell(8'h61, 4'd15, 0, 1); expect_cell(8'hF1, 4'd0, 0, 0);
    drain("R5");

    // R6 / R7: threshold and full drops on guaranteed line 6
    do_reset();
    for (int i = 0; i < 6; i++) begin
      put(0, 8'(8'h60 + i), 4'd6, 1, 0, 0); step("R6", 0);
    end
    put(0, 8'h66, 4'd6, 1, 0, 1); step("R6", 0);   // 6 stored: accepted
    put(0, 8'h67, 4'd6, 1, 0, 1); step("R6", 1);   // 7 stored: dropped
    put(0, 8'h68, 4'd6, 1, 0, 0); step("R6", 0);   // normal: accepted to 8
    put(0, 8'h69, 4'd6, 1, 0, 0); step("R7", 1);   // full
    put(0, 8'h6A, 4'd6, 1, 0, 0); put(1, 8'h6B, 4'd6, 1, 0, 0); step("R7", 2);
    for (int i = 0; i < 7; i++) expect_cell(8'(8'h60 + i), 4'd6, 0, 1);
    expect_cell(8'h68, 4'd6, 0, 1);
    drain("R6");

    // R2 / R6: line 1 admission counts line 0's cell of the same cycle
    do_reset();
    for (int i = 0; i < 6; i++) begin
      put(1, 8'(8'hA0 + i), 4'd10, 0, 0, 0); step("R2", 0);
    end
    put(0, 8'hA6, 4'd10, 0, 0, 0); put(1, 8'hA7, 4'd10, 0, 0, 1); step("R2", 1);
    for (int i = 0; i < 7; i++) expect_cell(8'(8'hA0 + i), 4'd10, 0, 0);
    drain("R6");

    // R10: reset empties stored cells
    put(0, 8'h77, 4'd2, 1, 0, 0); step("R10", 0);
    do_reset();
    check_idle("R10");
    put(0, 8'h78, 4'd2, 0, 0, 0); step("R10", 0);
    expect_cell(8'h78, 4'd2, 0, 0);
    drain("R10");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule